// File: doc/BRIEF.md
# Pipelined Multiply-Add Stream Unit

This block evaluates `a * b + c` on a stream of signed integer operand triples, one triple per clock, with no stalls. Three register segments do the work: the first latches the two factors, the second forms their full-width product and latches the addend next to it, and the third adds the two and registers the sum. The pipeline advances on every clock. Once it is full it delivers one result per clock for as long as operands keep arriving.

A valid bit travels beside the data through every segment. The result port is flagged valid exactly when the output register holds a real sum. The product is kept at twice the operand width and the sum at twice the width plus one, so no combination of operands can overflow. The addend normally arrives at the port one clock after its two factors, because that is the cycle in which the second segment needs it. A parameter can select instead an internal one-clock delay register, so that all three operands arrive together.

Top module: `mac_stream_pipe`

## Requirements
- R1: While reset is high, and on every clock after reset with no valid input, `out_valid` is 0.
- R2: A triple sampled with `in_valid` high at clock edge k produces `out_valid` high with its sum after edge k+2, which is the third edge counting the capture edge.
- R3: `out_sum` equals the signed value a*b+c, sign-extended to 2*W+1 bits, for all operand values, including the extremes -2^(W-1) and 2^(W-1)-1.
- R4: With `MODE` = `ADDEND_LATE` (the default), the addend for a triple is sampled from `in_c` at the edge after its factors. The value on `in_c` at the factor edge has no effect on that triple's sum. With `ADDEND_WITH_AB`, `in_c` is sampled together with the factors.
- R5: When `in_valid` is high on consecutive clocks, `out_valid` is high on the same number of consecutive clocks, and the results come out in input order.
- R6: A clock with `in_valid` low produces a clock with `out_valid` low two edges after it was sampled.
- R7: After input stops, the triples already in flight still emerge over the next clocks, and `out_valid` then stays low.
- R8: A synchronous reset asserted in the middle of a stream clears all in-flight valid bits, so `out_valid` is 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all segments advance on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| in_valid | input | 1 | Marks `in_a` and `in_b` as a new triple this clock |
| in_a | input | W | Signed first factor |
| in_b | input | W | Signed second factor |
| in_c | input | W | Signed addend; one clock after its factors by default |
| out_valid | output | 1 | `out_sum` holds a real result |
| out_sum | output | 2*W+1 | Signed a*b+c |

## Verification
At each clock edge of a back-to-back stream, the addend of one triple and the factors of the next triple are sampled in the same cycle from different ports. The bench provokes this by running unbroken streams in which `in_c` carries the addend of the previous triple while `in_a` and `in_b` carry the new factors. It also leaves a different junk value on `in_c` whenever no addend is due. A scoreboard compares every sum and its arrival cycle, so taking the addend one edge too early or too late shows up as a wrong sum. The same scoreboard flags results that are missing or appear where a gap was expected.

// File: rtl/mac_pipe_pkg.sv
package mac_pipe_pkg;

    // Cycle on which the addend is presented at the port.
    typedef enum logic {
        ADDEND_LATE    = 1'b0,  // one clock after its factors
        ADDEND_WITH_AB = 1'b1   // together with its factors
    } addend_mode_e;

endpackage

// File: rtl/mac_addend_delay.sv
// One-clock delay for the addend when it arrives with its factors.
module mac_addend_delay #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic [W-1:0] c_in,
    output logic [W-1:0] c_out
);

    logic [W-1:0] c_d, c_q;

    always_comb begin
        c_d = c_in;
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign c_out = c_q;

endmodule

// File: rtl/mac_mul_stage.sv
// Segments one and two: latch the factors, then multiply and latch the addend.
module mac_mul_stage #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           v_in,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic [W-1:0]   c_in,
    output logic           v_out,
    output logic [2*W-1:0] prod_out,
    output logic [W-1:0]   addend_out
);

    localparam int PW = 2 * W;

    typedef struct packed {
        logic          v1;
        logic [W-1:0]  fa;
        logic [W-1:0]  fb;
        logic          v2;
        logic [PW-1:0] prod;
        logic [W-1:0]  addend;
    } mul_state_t;

    mul_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.v1     = v_in;
        st_d.fa     = a_in;
        st_d.fb     = b_in;
        st_d.v2     = st_q.v1;
        st_d.prod   = {{W{st_q.fa[W-1]}}, st_q.fa} * {{W{st_q.fb[W-1]}}, st_q.fb};
        st_d.addend = c_in;
        if (rst) begin
            st_d.v1 = 1'b0;
            st_d.v2 = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign v_out      = st_q.v2;
    assign prod_out   = st_q.prod;
    assign addend_out = st_q.addend;

endmodule

// File: rtl/mac_add_stage.sv
// Segment three: add the aligned addend to the product.
module mac_add_stage #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           v_in,
    input  logic [2*W-1:0] prod_in,
    input  logic [W-1:0]   addend_in,
    output logic           v_out,
    output logic [2*W:0]   sum_out
);

    localparam int SW = 2 * W + 1;

    typedef struct packed {
        logic          v;
        logic [SW-1:0] sum;
    } add_state_t;

    add_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.v   = v_in;
        st_d.sum = {prod_in[2*W-1], prod_in} + {{(W+1){addend_in[W-1]}}, addend_in};
        if (rst) begin
            st_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign v_out   = st_q.v;
    assign sum_out = st_q.sum;

endmodule

// File: rtl/mac_stream_pipe.sv
module mac_stream_pipe
    import mac_pipe_pkg::*;
#(
    parameter int           W    = 16,
    parameter addend_mode_e MODE = ADDEND_LATE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    input  logic [W-1:0]   in_c,
    output logic           out_valid,
    output logic [2*W:0]   out_sum
);

    logic [W-1:0]   c_aligned;
    logic           mid_v;
    logic [2*W-1:0] mid_prod;
    logic [W-1:0]   mid_addend;

    generate
        if (MODE == ADDEND_WITH_AB) begin : g_delay
            mac_addend_delay #(.W(W)) u_delay (
                .clk   (clk),
                .c_in  (in_c),
                .c_out (c_aligned)
            );
        end else begin : g_direct
            assign c_aligned = in_c;
        end
    endgenerate

    mac_mul_stage #(.W(W)) u_mul (
        .clk        (clk),
        .rst        (rst),
        .v_in       (in_valid),
        .a_in       (in_a),
        .b_in       (in_b),
        .c_in       (c_aligned),
        .v_out      (mid_v),
        .prod_out   (mid_prod),
        .addend_out (mid_addend)
    );

    mac_add_stage #(.W(W)) u_add (
        .clk       (clk),
        .rst       (rst),
        .v_in      (mid_v),
        .prod_in   (mid_prod),
        .addend_in (mid_addend),
        .v_out     (out_valid),
        .sum_out   (out_sum)
    );

endmodule

// File: rtl/mac_stream_pipe_chk.sv
module mac_stream_pipe_chk
    import mac_pipe_pkg::*;
#(
    parameter int           W    = 16,
    parameter addend_mode_e MODE = ADDEND_LATE
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [W-1:0]   in_a,
    input logic [W-1:0]   in_b,
    input logic [W-1:0]   in_c,
    input logic           out_valid,
    input logic [2*W:0]   out_sum
);

    function automatic logic [2*W:0] ref_mac(logic [W-1:0] a, logic [W-1:0] b,
                                             logic [W-1:0] c);
        logic [2*W:0] ea, eb, ec;
        ea = {{(W+1){a[W-1]}}, a};
        eb = {{(W+1){b[W-1]}}, b};
        ec = {{(W+1){c[W-1]}}, c};
        return ea * eb + ec;
    endfunction

    // R1, R8: reset leaves no result flagged on the next clock
    a_r8_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

    // R2: a sampled triple is flagged at the output three edges later
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    // R6: a gap at the input is a gap at the output
    a_r6_bubble: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid);

    // R3, R4: the sum matches the operands taken on the right edges
    generate
        if (MODE == ADDEND_WITH_AB) begin : g_with
            a_r3_sum: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> out_sum == ref_mac($past(in_a, 3), $past(in_b, 3),
                                                 $past(in_c, 3)));
        end else begin : g_late
            a_r4_late_sum: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> out_sum == ref_mac($past(in_a, 3), $past(in_b, 3),
                                                 $past(in_c, 2)));
        end
    endgenerate

endmodule

bind mac_stream_pipe mac_stream_pipe_chk #(.W(W), .MODE(MODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_c      (in_c),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/mac_stream_pipe_test.sv
module mac_stream_pipe_test;

    localparam int W = 16;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_a = '0;
    logic signed [W-1:0] in_b = '0;
    logic signed [W-1:0] in_c = '0;
    logic                out_valid;
    logic [2*W:0]        out_sum;

    mac_stream_pipe #(.W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_c      (in_c),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    always #10 clk = ~clk;  // 50 MHz

    typedef struct {
        longint sum;
        int     cyc;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     errors = 0;
    int     cyc = 0;
    bit     done = 1'b0;
    bit                  prev_v = 1'b0;
    logic signed [W-1:0] prev_c = '0;
    int unsigned         seed = 32'h1234_5678;

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: factors now, addend of the previous triple now (R4 late addend).
    task automatic send(bit v, logic signed [W-1:0] a, logic signed [W-1:0] b,
                        logic signed [W-1:0] c);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        in_a     = v ? a : 16'sh3C3C;
        in_b     = v ? b : -16'sh0777;
        in_c     = prev_v ? prev_c : 16'sh5A5A;  // junk when no addend is due
        if (v) begin
            e.sum = longint'(a) * longint'(b) + longint'(c);
            e.cyc = cyc + 3;
            sb.push_back(e);
        end
        prev_v = v;
        prev_c = c;
    endtask

    function automatic logic signed [W-1:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[27:12];
    endfunction

    // Monitor: sample one time unit after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (!done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R6 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.cyc, "R2 latency", cyc, e.cyc);
                    check(longint'($signed(out_sum)) == e.sum, "R3 sum",
                          longint'($signed(out_sum)), e.sum);
                end
            end else if (sb.size() > 0 && sb[0].cyc <= cyc) begin
                check(1'b0, "R5 missing result", 0, 1);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 during reset", out_valid, 0);
        rst = 1'b0;
        repeat (4) send(1'b0, 0, 0, 0);
        check(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);

        // R3 directed values, including extremes
        send(1'b1, 16'sd3, 16'sd4, 16'sd5);
        send(1'b1, -16'sd32768, -16'sd32768, 16'sd32767);
        send(1'b1, 16'sd32767, -16'sd32768, -16'sd32768);
        send(1'b1, -16'sd1, 16'sd1, 16'sd0);
        send(1'b1, 16'sd32767, 16'sd32767, 16'sd32767);
        repeat (5) send(1'b0, 0, 0, 0);

        // R5 and R4: unbroken stream, in_c carries the previous triple's addend
        for (int i = 0; i < 24; i++) send(1'b1, rnd(), rnd(), rnd());
        repeat (5) send(1'b0, 0, 0, 0);

        // R6: gaps in the stream
        for (int i = 0; i < 30; i++) send(i % 3 != 0, rnd(), rnd(), rnd());
        for (int i = 0; i < 20; i++) send(i % 2 == 1, rnd(), rnd(), rnd());

        // R7: stop and drain
        repeat (6) send(1'b0, 0, 0, 0);
        check(sb.size() == 0, "R7 drained", sb.size(), 0);
        check(out_valid == 1'b0, "R7 idle after drain", out_valid, 0);

        // R8: reset in the middle of a stream
        for (int i = 0; i < 3; i++) send(1'b1, rnd(), rnd(), rnd());
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        prev_v   = 1'b0;
        sb.delete();
        @(posedge clk);
        #2;
        check(out_valid == 1'b0, "R8 reset clears", out_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) send(1'b0, 0, 0, 0);
        check(out_valid == 1'b0, "R8 nothing after reset", out_valid, 0);
        send(1'b1, 16'sd100, -16'sd7, 16'sd42);
        repeat (5) send(1'b0, 0, 0, 0);
        check(sb.size() == 0, "R8 recovers", sb.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule